// File: doc/BRIEF.md
# Booth-Recoded Lookup Multiplier Array

This block multiplies a stream of signed 8-bit activations by a group of signed weights. All the weights of the group sit in one 72-bit word of an internal weight memory. Each activation is recoded into four radix-4 Booth digits. Each digit picks zero, the weight or the doubled weight of every channel, and negates the pick when the digit is negative. The four partial products are shifted into place and summed, and the sum is added to a 32-bit accumulator kept for each channel.

The weight memory stores each weight next to its own double. One read therefore serves all four digits of an activation. A precision input is captured together with each activation. It selects 4-, 6- or 8-bit weights, and the same 72-bit word then holds 8, 5 or 4 channels. Weights are written through a simple synchronous write port. A reduction-start pulse restarts the accumulators.

The datapath has three registered steps: Booth recoding together with the memory read, partial-product selection and summation, and accumulation. The result of an activation is visible on the outputs three clock edges after it is presented.

Top module: `booth_lut_mac`

## Requirements
- R1: After a synchronous active-high reset, every accumulator output reads 0 and `acc_valid` is low.
- R2: An activation presented with `act_valid` high at clock edge k updates the accumulators at edge k+3. `acc_valid` is high after edge k+3 exactly when `act_valid` was high at edge k.
- R3: Each activation is split into four radix-4 Booth digits. Digit i is taken from bits a[2i+1], a[2i] and a[2i-1], with a[-1]=0. The channel product equals the signed product a*w for all 256 activation values.
- R4: Precision code 0 selects 4-bit weights with 8 channels. Each channel uses a 9-bit field at bit 9*c: w is in field bits [3:0] and 2w in bits [8:4].
- R5: Precision code 1 selects 6-bit weights with 5 channels. Each channel uses a 13-bit field at bit 13*c: w is in bits [5:0] and 2w in bits [12:6].
- R6: Precision codes 2 and 3 select 8-bit weights with 4 channels. Each channel uses a 17-bit field at bit 17*c: w is in bits [7:0] and 2w in bits [16:8].
- R7: The most negative weight of each precision (-8, -32, -128) gives the exact signed product for every activation.
- R8: Channels above the group size of the selected precision add nothing. Word bits above the last channel (bits 71:65 at code 1, bits 71:68 at codes 2 and 3) have no effect.
- R9: Without `clear`, each accepted activation adds its product to the running 32-bit sum of the channel.
- R10: `clear` with `act_valid` loads each accumulator with the product of that activation. `clear` alone loads 0 at the same edge position as in R2 and leaves `acc_valid` low.
- R11: Each activation reads exactly one memory word, selected by `rd_addr` at the edge where the activation is taken. A write at edge k is visible to reads taken at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Weight memory write enable |
| wr_addr | input | 6 | Weight memory write address |
| wr_data | input | 72 | Packed weight word to write |
| act_valid | input | 1 | Activation present this cycle |
| act | input | 8 | Signed activation |
| rd_addr | input | 6 | Weight word used by this activation |
| prec | input | 2 | Weight precision code (0: 4-bit, 1: 6-bit, 2/3: 8-bit) |
| clear | input | 1 | Reduction start: restart the accumulators |
| acc_valid | output | 1 | Accumulators just took an activation |
| acc_out | output | 256 | Eight 32-bit signed accumulators, channel c at bits [32c+31:32c] |

## Verification
Every one of the 256 activation values is applied with `clear` against words of all-most-negative weights, all-most-positive weights and random weights, at each precision code. The extreme words expose sign and negation faults in the doubled-weight path, and the random words expose swapped or misplaced channel fields. Unused high bits and unused channel fields are filled with ones or random data, so a decoder that reads past the group size shows up as nonzero upper channels. Back-to-back runs without `clear`, and a lone `clear`, separate correct accumulation from a design that only reloads or never restarts.

// File: rtl/booth_pkg.sv
package booth_pkg;

  localparam int ACT_W    = 8;
  localparam int NDIG     = ACT_W / 2;
  localparam int WORD_W   = 72;
  localparam int MAX_CH   = 8;
  localparam int WMAX     = 8;
  localparam int SEL_W    = WMAX + 2;
  localparam int PROD_W   = 2 * ACT_W;

  typedef enum logic [1:0] {
    PREC_W4  = 2'd0,
    PREC_W6  = 2'd1,
    PREC_W8  = 2'd2,
    PREC_W8B = 2'd3
  } prec_t;

  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } bdigit_t;

  function automatic int chan_count(input int bits);
    return WORD_W / (2 * bits + 1);
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
#(
  parameter int A_W = ACT_W,
  localparam int ND = A_W / 2
) (
  input  logic [A_W-1:0]          a,
  output bdigit_t [ND-1:0]        dig
);

  logic [A_W:0] ext;
  assign ext = {a, 1'b0};

  genvar i;
  generate
    for (i = 0; i < ND; i++) begin : g_dig
      logic [2:0] tri_bits;
      assign tri_bits = ext[2*i +: 3];
      always_comb begin
        dig[i] = '0;
        unique case (tri_bits)
          3'b001, 3'b010: dig[i].one = 1'b1;
          3'b011:         dig[i].two = 1'b1;
          3'b100:         begin dig[i].two = 1'b1; dig[i].neg = 1'b1; end
          3'b101, 3'b110: begin dig[i].one = 1'b1; dig[i].neg = 1'b1; end
          default:        dig[i] = '0;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/booth_field_unpack.sv
module booth_field_unpack
  import booth_pkg::*;
#(
  parameter int CH = 0,
  parameter int W_WORD = WORD_W,
  localparam int S_W = SEL_W
) (
  input  logic [W_WORD-1:0]     word,
  input  prec_t                 prec,
  output logic signed [S_W-1:0] w1,
  output logic signed [S_W-1:0] w2,
  output logic                  live
);

  localparam int F4 = 9;
  localparam int F6 = 13;
  localparam int F8 = 17;
  localparam bit HAS4 = CH < chan_count(4);
  localparam bit HAS6 = CH < chan_count(6);
  localparam bit HAS8 = CH < chan_count(8);

  logic signed [S_W-1:0] w1_4, w2_4, w1_6, w2_6, w1_8, w2_8;

  generate
    if (HAS4) begin : g_f4
      logic [F4-1:0] f;
      assign f    = word[CH*F4 +: F4];
      assign w1_4 = S_W'($signed(f[3:0]));
      assign w2_4 = S_W'($signed(f[8:4]));
    end else begin : g_n4
      assign w1_4 = '0;
      assign w2_4 = '0;
    end
    if (HAS6) begin : g_f6
      logic [F6-1:0] f;
      assign f    = word[CH*F6 +: F6];
      assign w1_6 = S_W'($signed(f[5:0]));
      assign w2_6 = S_W'($signed(f[12:6]));
    end else begin : g_n6
      assign w1_6 = '0;
      assign w2_6 = '0;
    end
    if (HAS8) begin : g_f8
      logic [F8-1:0] f;
      assign f    = word[CH*F8 +: F8];
      assign w1_8 = S_W'($signed(f[7:0]));
      assign w2_8 = S_W'($signed(f[16:8]));
    end else begin : g_n8
      assign w1_8 = '0;
      assign w2_8 = '0;
    end
  endgenerate

  always_comb begin
    unique case (prec)
      PREC_W4: begin w1 = w1_4; w2 = w2_4; live = HAS4; end
      PREC_W6: begin w1 = w1_6; w2 = w2_6; live = HAS6; end
      default: begin w1 = w1_8; w2 = w2_8; live = HAS8; end
    endcase
  end

endmodule

// File: rtl/booth_pp_sum.sv
module booth_pp_sum
  import booth_pkg::*;
#(
  parameter int ND  = NDIG,
  parameter int S_W = SEL_W,
  parameter int P_W = PROD_W
) (
  input  bdigit_t [ND-1:0]        dig,
  input  logic signed [S_W-1:0]   w1,
  input  logic signed [S_W-1:0]   w2,
  input  logic                    live,
  output logic signed [P_W-1:0]   prod
);

  logic signed [P_W-1:0] pp [ND];

  genvar i;
  generate
    for (i = 0; i < ND; i++) begin : g_pp
      logic signed [S_W-1:0] mag;
      logic signed [S_W-1:0] sgn;
      always_comb begin
        if (dig[i].one)      mag = w1;
        else if (dig[i].two) mag = w2;
        else                 mag = '0;
        sgn   = dig[i].neg ? (~mag + S_W'(1)) : mag;
        pp[i] = P_W'(sgn) <<< (2 * i);
      end
    end
  endgenerate

  always_comb begin
    prod = '0;
    if (live) begin
      for (int k = 0; k < ND; k++) prod = prod + pp[k];
    end
  end

endmodule

// File: rtl/booth_acc.sv
module booth_acc #(
  parameter int P_W = 16,
  parameter int A_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic                  restart,
  input  logic signed [P_W-1:0] prod,
  output logic signed [A_W-1:0] acc
);

  logic signed [A_W-1:0] base;
  assign base = restart ? '0 : acc;

  always_ff @(posedge clk) begin
    if (rst)                  acc <= '0;
    else if (take)            acc <= base + A_W'(prod);
    else if (restart)         acc <= '0;
  end

endmodule

// File: rtl/booth_lut_mac.sv
module booth_lut_mac
  import booth_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int ACC_W  = 32,
  parameter int NCH    = MAX_CH,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [WORD_W-1:0]      wr_data,
  input  logic                   act_valid,
  input  logic [ACT_W-1:0]       act,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [1:0]             prec,
  input  logic                   clear,
  output logic                   acc_valid,
  output logic [NCH*ACC_W-1:0]   acc_out
);

  // weight memory, single write port and registered read
  logic [WORD_W-1:0] wmem [DEPTH];
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (wr_en) wmem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    word_q <= wmem[rd_addr];
  end

  // stage 1: recode and capture control
  bdigit_t [NDIG-1:0] dig_d, dig_q;
  prec_t              prec_q;
  logic               v1_q, c1_q;

  booth_recoder #(.A_W(ACT_W)) u_rec (
    .a   (act),
    .dig (dig_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_q  <= '0;
      prec_q <= PREC_W4;
      v1_q   <= 1'b0;
      c1_q   <= 1'b0;
    end else begin
      dig_q  <= dig_d;
      prec_q <= prec_t'(prec);
      v1_q   <= act_valid;
      c1_q   <= clear;
    end
  end

  // stage 2: partial-product selection per channel
  logic signed [PROD_W-1:0] prod_d [NCH];
  logic signed [PROD_W-1:0] prod_q [NCH];
  logic                     v2_q, c2_q;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic signed [SEL_W-1:0] w1, w2;
      logic                    live;

      booth_field_unpack #(.CH(c), .W_WORD(WORD_W)) u_unp (
        .word (word_q),
        .prec (prec_q),
        .w1   (w1),
        .w2   (w2),
        .live (live)
      );

      booth_pp_sum #(.ND(NDIG), .S_W(SEL_W), .P_W(PROD_W)) u_pp (
        .dig  (dig_q),
        .w1   (w1),
        .w2   (w2),
        .live (live),
        .prod (prod_d[c])
      );

      always_ff @(posedge clk) begin
        if (rst) prod_q[c] <= '0;
        else     prod_q[c] <= prod_d[c];
      end

      logic signed [ACC_W-1:0] acc;

      booth_acc #(.P_W(PROD_W), .A_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .take    (v2_q),
        .restart (c2_q),
        .prod    (prod_q[c]),
        .acc     (acc)
      );

      assign acc_out[c*ACC_W +: ACC_W] = acc;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      v2_q      <= 1'b0;
      c2_q      <= 1'b0;
      acc_valid <= 1'b0;
    end else begin
      v2_q      <= v1_q;
      c2_q      <= c1_q;
      acc_valid <= v2_q;
    end
  end

endmodule

// File: rtl/booth_lut_mac_chk.sv
module booth_lut_mac_chk #(
  parameter int NCH   = 8,
  parameter int ACC_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 act_valid,
  input logic                 clear,
  input logic [1:0]           prec,
  input logic                 acc_valid,
  input logic [NCH*ACC_W-1:0] acc_out
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (acc_out == '0 && !acc_valid));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> ##3 acc_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !act_valid |-> ##3 !acc_valid);

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && !act_valid) |-> ##3 (acc_out == '0));

  // R8
  unused8_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (prec[1] && act_valid && !clear) |-> ##3 $stable(acc_out[NCH*ACC_W-1:4*ACC_W]));

  // R8
  unused6_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (prec == 2'd1 && act_valid && !clear) |-> ##3 $stable(acc_out[NCH*ACC_W-1:5*ACC_W]));

endmodule

bind booth_lut_mac booth_lut_mac_chk #(.NCH(NCH), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .act_valid (act_valid),
  .clear     (clear),
  .prec      (prec),
  .acc_valid (acc_valid),
  .acc_out   (acc_out)
);

// File: tb/booth_lut_mac_test.sv
module booth_lut_mac_test;

  localparam int NCH = 8;
  localparam int AW  = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [71:0]       wr_data;
  logic              act_valid;
  logic [7:0]        act;
  logic [AW-1:0]     rd_addr;
  logic [1:0]        prec;
  logic              clear;
  logic              acc_valid;
  logic [NCH*32-1:0] acc_out;

  int n_chk  = 0;
  int n_fail = 0;
  int wt [6][NCH];
  logic done = 1'b0;

  always #5 clk = ~clk;

  booth_lut_mac uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_valid(act_valid), .act(act), .rd_addr(rd_addr), .prec(prec),
    .clear(clear), .acc_valid(acc_valid), .acc_out(acc_out)
  );

  function automatic int bits_of(input int p);
    return (p == 0) ? 4 : (p == 1) ? 6 : 8;
  endfunction

  function automatic int nch_of(input int p);
    return (p == 0) ? 8 : (p == 1) ? 5 : 4;
  endfunction

  function automatic int acc_ch(input int c);
    return $signed(acc_out[c*32 +: 32]);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Pack a word: per channel {2w, w}; fields beyond the group get junk.
  task automatic load_word(input int addr, input int p, input bit junk_ones);
    logic [71:0] word;
    int b, f;
    b = bits_of(p);
    f = 2 * b + 1;
    word = junk_ones ? {72{1'b1}} : {$urandom, $urandom, $urandom};
    for (int c = 0; c < nch_of(p); c++) begin
      logic [16:0] fld;
      logic [16:0] two;
      two = 17'(wt[addr][c] * 2);
      fld = 17'(wt[addr][c]) & ((17'd1 << b) - 17'd1);
      fld = fld | ((two & ((17'd1 << (b + 1)) - 17'd1)) << b);
      for (int k = 0; k < f; k++) word[c*f + k] = fld[k];
    end
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = word;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input int a, input int addr, input int p, input bit v, input bit clr);
    act_valid = v; act = 8'(a); rd_addr = AW'(addr); prec = 2'(p); clear = clr;
    @(negedge clk);
    act_valid = 1'b0; clear = 1'b0;
  endtask

  task automatic sweep(input int p, input int code);
    string rq;
    int lo, hi;
    lo = -(1 << (bits_of(p) - 1));
    hi = (1 << (bits_of(p) - 1)) - 1;
    rq = (p == 0) ? "R4" : (p == 1) ? "R5" : "R6";
    for (int s = 0; s < 6; s++)
      for (int c = 0; c < NCH; c++)
        wt[s][c] = (s == 0) ? lo : (s == 1) ? hi : lo + int'($urandom % (hi - lo + 1));
    for (int s = 0; s < 6; s++) load_word(s, p, s[0]);
    for (int s = 0; s < 6; s++) begin
      for (int a = 0; a < 256; a++) begin
        int sa;
        sa = (a > 127) ? a - 256 : a;
        @(negedge clk);
        drive(a, s, code, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        check("R2 acc_valid", int'(acc_valid), 1);
        for (int c = 0; c < NCH; c++) begin
          int e;
          e = (c < nch_of(p)) ? sa * wt[s][c] : 0;
          if (c >= nch_of(p))  check("R8 unused channel", acc_ch(c), e);
          else if (s == 0)     check("R7 most negative", acc_ch(c), e);
          else if (a == 128)   check("R3 act -128", acc_ch(c), e);
          else                 check(rq, acc_ch(c), e);
        end
      end
    end
    // R9: back-to-back accumulation over several words
    begin
      int sum [NCH];
      for (int c = 0; c < NCH; c++) sum[c] = 0;
      @(negedge clk);
      for (int k = 0; k < 7; k++) begin
        int a, sa, s;
        a = int'($urandom % 256);
        if (k == 2) a = 128;
        sa = (a > 127) ? a - 256 : a;
        s = k % 6;
        for (int c = 0; c < nch_of(p); c++) sum[c] = ((k == 0) ? 0 : sum[c]) + sa * wt[s][c];
        act_valid = 1'b1; act = 8'(a); rd_addr = AW'(s); prec = 2'(code); clear = (k == 0);
        @(negedge clk);
      end
      act_valid = 1'b0; clear = 1'b0;
      @(negedge clk);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) check("R9 accumulate", acc_ch(c), sum[c]);
    end
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    act_valid = 1'b0; act = '0; rd_addr = '0; prec = '0; clear = 1'b0;
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 acc_valid", int'(acc_valid), 0);
    for (int c = 0; c < NCH; c++) check("R1 acc", acc_ch(c), 0);

    sweep(0, 0);
    sweep(1, 1);
    sweep(2, 2);
    sweep(2, 3);

    // R10: clear alone zeroes and leaves acc_valid low
    @(negedge clk);
    drive(0, 0, 0, 1'b0, 1'b1);
    @(negedge clk);
    check("R10 no valid", int'(acc_valid), 0);
    @(negedge clk);
    check("R10 no valid", int'(acc_valid), 0);
    for (int c = 0; c < NCH; c++) check("R10 clear only", acc_ch(c), 0);

    // R11: overwrite a word, read it at the next edge
    for (int c = 0; c < NCH; c++) wt[3][c] = 5 - c;
    load_word(3, 0, 1'b0);
    drive(3, 3, 0, 1'b1, 1'b1);
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R11 fresh word", acc_ch(c), 3 * (5 - c));

    // R1: reset in the middle of activity
    drive(7, 3, 0, 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 mid reset valid", int'(acc_valid), 0);
    for (int c = 0; c < NCH; c++) check("R1 mid reset acc", acc_ch(c), 0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule